// File: doc/BRIEF.md
# Status-Flag ALU

This block is an 8/16-bit arithmetic and logic unit that keeps a packed 16-bit status word beside its result register. On each cycle where an operation is presented, it adds, adds with an incoming carry, subtracts, compares, ANDs, ORs, XORs, or shifts one operand by a single bit. A width select chooses whether the low byte or the full 16-bit word takes part. One clock edge later, the result register and the status word hold the outcome.

Each operation rewrites only the status bits it defines, and every other bit keeps its value. Three control bits (direction, interrupt enable and single-step trap) are never touched by data operations. Six dedicated commands set or clear them. A compare works like a subtract but leaves the result register alone. The block has no state machine of its own. Its only state is the result register and the status register, both cleared by an asynchronous active-low reset.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0x0000 and `flags` is 0x0002.
- R2: In `flags`, bit 1 always reads 1, and bits 3, 5 and 12 to 15 always read 0.
- R3: ADD writes a+b and ADC writes a+b+`carry_in`, both truncated to the selected width. Carry (bit 0) is the carry out of the top bit, auxiliary carry (bit 4) is the carry from bit 3 into bit 4, and overflow (bit 11) is set when the signed sum does not fit the width.
- R4: SUB writes a-b. Carry (bit 0) is set on an unsigned borrow, auxiliary carry (bit 4) on a borrow into bit 4, and overflow (bit 11) when the signed difference does not fit. CMP sets the same flags but leaves `result` unchanged.
- R5: For every arithmetic, logical and shift operation, zero (bit 6) is set when the width-limited result is all zeros. Sign (bit 7) copies the result's top bit. Parity (bit 2) is set when the low 8 result bits hold an even number of ones.
- R6: AND, OR and XOR write the bitwise result, clear carry and overflow, and leave auxiliary carry unchanged.
- R7: SHL shifts a left by one and fills a 0 at the bottom. Carry takes the bit shifted out of the top, and overflow is set when the new top bit differs from that carry. SHR shifts a right by one and fills a 0 at the top. Carry takes old bit 0, and overflow takes the old top bit. Both leave auxiliary carry unchanged and ignore b.
- R8: With `wide`=0, only the low 8 bits of the operands take part, `result[15:8]` is written as 0, and carry, sign and overflow refer to bit 7. With `wide`=1, all 16 bits take part.
- R9: The commands set-direction and clear-direction drive bit 10, set-interrupt and clear-interrupt drive bit 9, and set-trap and clear-trap drive bit 8. These commands change nothing else. No other operation changes bits 8 to 10.
- R10: When `op_valid` is 0, or the opcode is NONE, `result` and `flags` hold their values.
- R11: `op_code` values are NONE=0, ADD=1, ADC=2, SUB=3, CMP=4, AND=5, OR=6, XOR=7, SHL=8, SHR=9, set-direction=10, clear-direction=11, set-interrupt=12, clear-interrupt=13, set-trap=14, clear-trap=15. An operation sampled at one rising edge shows on `result` and `flags` after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R11) |
| wide | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| opa | input | 16 | First operand; the one shifted by SHL/SHR |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry, used by ADC only |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered status and control word |

## Verification
All state sits in two registers that feed the ports directly. A wrong bit in either one therefore shows at the next sampling point after the edge that wrote it. A status bit that should have been kept shows up as a mismatch against the bench model when it is next read, and every later operation is checked against the full word. A lane-selection error, such as a wrong bit 7 versus bit 15 reference or a non-zero upper byte, shows up on the first narrow operation with a carry or sign in the upper byte. A stray write to the control bits shows up as soon as any data operation follows a control command.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_ADD       = 4'd1,
        OP_ADC       = 4'd2,
        OP_SUB       = 4'd3,
        OP_CMP       = 4'd4,
        OP_AND       = 4'd5,
        OP_OR        = 4'd6,
        OP_XOR       = 4'd7,
        OP_SHL       = 4'd8,
        OP_SHR       = 4'd9,
        OP_SET_DIR   = 4'd10,
        OP_CLR_DIR   = 4'd11,
        OP_SET_INT   = 4'd12,
        OP_CLR_INT   = 4'd13,
        OP_SET_TRAP  = 4'd14,
        OP_CLR_TRAP  = 4'd15
    } alu_op_e;

    localparam int FLAG_W    = 16;
    localparam int FB_CARRY  = 0;
    localparam int FB_PARITY = 2;
    localparam int FB_AUX    = 4;
    localparam int FB_ZERO   = 6;
    localparam int FB_SIGN   = 7;
    localparam int FB_TRAP   = 8;
    localparam int FB_INT    = 9;
    localparam int FB_DIR    = 10;
    localparam int FB_OVF    = 11;

    localparam logic [FLAG_W-1:0] FLAGS_FIXED_ONE = 16'h0002;
    localparam logic [FLAG_W-1:0] FLAGS_LIVE_MASK = 16'h0FD5;
    localparam logic [FLAG_W-1:0] FLAGS_RESET     = FLAGS_FIXED_ONE;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } stat_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         cf,
    output logic         af,
    output logic         of
);
    logic [W:0] ext;

    always_comb begin
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b};
        end else begin
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        r  = ext[W-1:0];
        cf = ext[W];
        af = a[4] ^ b[4] ^ ext[4];
        if (sub) begin
            of = (a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
        end else begin
            of = ~(a[W-1] ^ b[W-1]) & (ext[W-1] ^ a[W-1]);
        end
    end
endmodule

// File: rtl/alu_logshift.sv
module alu_logshift
    import alu_flags_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r,
    output logic         cf,
    output logic         of
);
    always_comb begin
        r  = '0;
        cf = 1'b0;
        of = 1'b0;
        case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_SHL: begin
                r  = {a[W-2:0], 1'b0};
                cf = a[W-1];
                of = a[W-1] ^ a[W-2];
            end
            OP_SHR: begin
                r  = {1'b0, a[W-1:1]};
                cf = a[0];
                of = a[W-1];
            end
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] r,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    assign zf = (r == '0);
    assign sf = r[W-1];
    assign pf = ~^r[7:0];
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              wide,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    localparam int N_LANES = 2;

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic is_sub;
    logic use_cin;
    assign is_sub  = (op == OP_SUB) || (op == OP_CMP);
    assign use_cin = (op == OP_ADC) && carry_in;

    logic [DATA_W-1:0] ar_res [N_LANES];
    logic [DATA_W-1:0] lg_res [N_LANES];
    stat_t             ar_st  [N_LANES];
    stat_t             lg_st  [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;

        logic [LW-1:0] a_l, b_l, ar_r, lg_r;
        logic ar_cf, ar_af, ar_of, lg_cf, lg_of;
        logic ar_zf, ar_sf, ar_pf, lg_zf, lg_sf, lg_pf;
        stat_t st_a, st_l;

        assign a_l = opa[LW-1:0];
        assign b_l = opb[LW-1:0];

        alu_addsub #(.W(LW)) u_arith (
            .a(a_l), .b(b_l), .cin(use_cin), .sub(is_sub),
            .r(ar_r), .cf(ar_cf), .af(ar_af), .of(ar_of)
        );

        alu_logshift #(.W(LW)) u_logic (
            .op(op), .a(a_l), .b(b_l),
            .r(lg_r), .cf(lg_cf), .of(lg_of)
        );

        alu_status #(.W(LW)) u_stat_a (.r(ar_r), .zf(ar_zf), .sf(ar_sf), .pf(ar_pf));
        alu_status #(.W(LW)) u_stat_l (.r(lg_r), .zf(lg_zf), .sf(lg_sf), .pf(lg_pf));

        always_comb begin
            st_a.cf = ar_cf;
            st_a.pf = ar_pf;
            st_a.af = ar_af;
            st_a.zf = ar_zf;
            st_a.sf = ar_sf;
            st_a.of = ar_of;
            st_l.cf = lg_cf;
            st_l.pf = lg_pf;
            st_l.af = 1'b0;
            st_l.zf = lg_zf;
            st_l.sf = lg_sf;
            st_l.of = lg_of;
        end

        assign ar_res[g] = DATA_W'(ar_r);
        assign lg_res[g] = DATA_W'(lg_r);
        assign ar_st[g]  = st_a;
        assign lg_st[g]  = st_l;
    end

    function automatic logic [FLAG_W-1:0] put_stat(
        input logic [FLAG_W-1:0] f,
        input stat_t             s,
        input logic              with_af
    );
        logic [FLAG_W-1:0] n;
        n            = f;
        n[FB_CARRY]  = s.cf;
        n[FB_PARITY] = s.pf;
        n[FB_ZERO]   = s.zf;
        n[FB_SIGN]   = s.sf;
        n[FB_OVF]    = s.of;
        if (with_af) begin
            n[FB_AUX] = s.af;
        end
        return n;
    endfunction

    logic              sel;
    logic [DATA_W-1:0] res_q, res_d;
    logic [FLAG_W-1:0] flags_q, flags_d, flags_raw;

    assign sel = wide;

    always_comb begin
        res_d     = res_q;
        flags_raw = flags_q;
        if (op_valid) begin
            unique case (op)
                OP_NONE: ;
                OP_ADD, OP_ADC, OP_SUB: begin
                    res_d     = ar_res[sel];
                    flags_raw = put_stat(flags_q, ar_st[sel], 1'b1);
                end
                OP_CMP: flags_raw = put_stat(flags_q, ar_st[sel], 1'b1);
                OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: begin
                    res_d     = lg_res[sel];
                    flags_raw = put_stat(flags_q, lg_st[sel], 1'b0);
                end
                OP_SET_DIR:  flags_raw[FB_DIR]  = 1'b1;
                OP_CLR_DIR:  flags_raw[FB_DIR]  = 1'b0;
                OP_SET_INT:  flags_raw[FB_INT]  = 1'b1;
                OP_CLR_INT:  flags_raw[FB_INT]  = 1'b0;
                OP_SET_TRAP: flags_raw[FB_TRAP] = 1'b1;
                OP_CLR_TRAP: flags_raw[FB_TRAP] = 1'b0;
            endcase
        end
        flags_d = (flags_raw & FLAGS_LIVE_MASK) | FLAGS_FIXED_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= FLAGS_RESET;
        end else begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    assign result = res_q;
    assign flags  = flags_q;
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              wide,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags
);
    logic is_logic, is_data, writes_res, is_cmd, idle;
    assign is_logic   = op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);
    assign is_data    = op_valid && (op_code >= OP_ADD) && (op_code <= OP_SHR);
    assign writes_res = is_data && (op_code != OP_CMP);
    assign is_cmd     = op_valid && (op_code >= OP_SET_DIR);
    assign idle       = !op_valid || (op_code == OP_NONE);

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] && ((flags & 16'hF028) == 16'h0000));

    p_cmp_keeps_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> $stable(result));

    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        writes_res |=> (flags[FB_ZERO] == ($past(wide) ? (result == '0) : (result[7:0] == 8'h00))));

    p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (!flags[FB_CARRY] && !flags[FB_OVF] && $stable(flags[FB_AUX])));

    p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (writes_res && !wide) |=> (result[DATA_W-1:8] == '0));

    p_ctrl_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |=> $stable(flags[FB_DIR:FB_TRAP]));

    p_cmd_only_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> ($stable(result) && $stable(flags[7:0]) && $stable(flags[FB_OVF])));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(result) && $stable(flags)));
endmodule

bind alu_flags_unit alu_flags_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wide(wide), .result(result), .flags(flags)
);

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        wide = 1'b0;
    logic [15:0] opa = 16'h0, opb = 16'h0;
    logic        carry_in = 1'b0;
    logic [15:0] result, flags;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_res = 16'h0000;
    logic [15:0] m_flags = 16'h0002;

    always #4 clk = ~clk;

    alu_flags_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wide(wide), .opa(opa), .opb(opb), .carry_in(carry_in),
        .result(result), .flags(flags)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input bit v);
        if (!v || op == 0) return "R10";
        if (op <= 2) return "R3";
        if (op <= 4) return "R4";
        if (op <= 7) return "R6";
        if (op <= 9) return "R7";
        return "R9";
    endfunction

    function automatic logic [31:0] model(input int op, input bit w, input logic [15:0] a,
                                          input logic [15:0] b, input bit ci,
                                          input logic [15:0] r0, input logic [15:0] f0);
        int n = w ? 16 : 8;
        int msk = (1 << n) - 1;
        int half = 1 << (n - 1);
        int ua = int'(a) & msk;
        int ub = int'(b) & msk;
        int sa = (ua >= half) ? ua - (1 << n) : ua;
        int sb = (ub >= half) ? ub - (1 << n) : ub;
        int c = (op == 2 && ci) ? 1 : 0;
        int full, s, rr;
        bit cf, af, of;
        logic [15:0] r = r0, f = f0;
        rr = 0; cf = 0; af = f0[4]; of = 0;
        case (op)
            1, 2: begin
                full = ua + ub + c; rr = full & msk; cf = full > msk;
                af = ((ua & 15) + (ub & 15) + c) > 15;
                s = sa + sb + c; of = (s >= half) || (s < -half);
            end
            3, 4: begin
                full = ua - ub; rr = full & msk; cf = ua < ub;
                af = (ua & 15) < (ub & 15);
                s = sa - sb; of = (s >= half) || (s < -half);
            end
            5: rr = ua & ub;
            6: rr = ua | ub;
            7: rr = ua ^ ub;
            8: begin rr = (ua << 1) & msk; cf = ((ua >> (n-1)) & 1) != 0; of = (((rr >> (n-1)) & 1) != 0) ^ cf; end
            9: begin rr = ua >> 1; cf = (ua & 1) != 0; of = ((ua >> (n-1)) & 1) != 0; end
            default: ;
        endcase
        if (op >= 1 && op <= 9) begin
            if (op != 4) r = 16'(rr);
            f[0] = cf; f[4] = af; f[11] = of;
            f[6] = (rr == 0);
            f[7] = ((rr >> (n-1)) & 1) != 0;
            f[2] = ($countones(16'(rr & 255)) % 2) == 0;
        end
        case (op)
            10: f[10] = 1'b1;
            11: f[10] = 1'b0;
            12: f[9]  = 1'b1;
            13: f[9]  = 1'b0;
            14: f[8]  = 1'b1;
            15: f[8]  = 1'b0;
            default: ;
        endcase
        return {r, f};
    endfunction

    task automatic run_op(input int op, input bit v, input bit w, input logic [15:0] a,
                          input logic [15:0] b, input bit ci);
        logic [31:0] nx;
        string t;
        op_valid = v; op_code = op[3:0]; wide = w; opa = a; opb = b; carry_in = ci;
        @(posedge clk);
        @(negedge clk);
        nx = v ? model(op, w, a, b, ci, m_res, m_flags) : {m_res, m_flags};
        t = tag_of(op, v);
        check(result == nx[31:16], {t, " result"}, result, nx[31:16]);
        check(flags == nx[15:0], {t, " flags"}, flags, nx[15:0]);
        check(flags[1] && ((flags & 16'hF028) == 0), "R2 fixed bits", flags, 16'h0002);
        if (v && op >= 1 && op <= 9)
            check((flags & 16'h00C4) == (nx[15:0] & 16'h00C4), "R5 zero/sign/parity", flags & 16'h00C4, nx[15:0] & 16'h00C4);
        if (v && !w && op >= 1 && op <= 9 && op != 4)
            check(result[15:8] == 8'h00, "R8 narrow upper byte", result, nx[31:16]);
        m_res = nx[31:16];
        m_flags = nx[15:0];
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(result == 16'h0000, "R1 reset result", result, 16'h0000);
        check(flags == 16'h0002, "R1 reset flags", flags, 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 16'h0000 && flags == 16'h0002, "R1 after release", flags, 16'h0002);

        // R11: not visible before the sampling edge
        op_valid = 1'b1; op_code = 4'd1; wide = 1'b1; opa = 16'h1234; opb = 16'h1111;
        #1 check(result == 16'h0000, "R11 no combinational path", result, 16'h0000);
        run_op(1, 1, 1, 16'h1234, 16'h1111, 0);
        check(result == 16'h2345, "R11 one-cycle result", result, 16'h2345);

        // R3 corners, narrow and wide
        run_op(1, 1, 0, 16'h000F, 16'h0001, 0);   // aux carry
        run_op(1, 1, 0, 16'h007F, 16'h0001, 0);   // signed overflow, sign
        run_op(1, 1, 0, 16'hAAFF, 16'h5501, 0);   // zero, carry, upper byte dropped
        run_op(2, 1, 1, 16'hFFFF, 16'h0000, 1);   // ADC wraps
        run_op(2, 1, 0, 16'h0010, 16'h0020, 1);
        // R4 corners
        run_op(3, 1, 1, 16'h8000, 16'h0001, 0);   // signed overflow
        run_op(3, 1, 0, 16'h0000, 16'h0001, 0);   // borrow
        run_op(4, 1, 1, 16'h0005, 16'h0005, 0);   // CMP equal, result held
        check(result == 16'h00FF, "R4 compare leaves result", result, 16'h00FF);
        // R6 logic after a carry-setting op
        run_op(1, 1, 1, 16'hFFFF, 16'h0001, 0);
        run_op(5, 1, 1, 16'hF0F0, 16'h0F0F, 0);
        run_op(7, 1, 0, 16'h00A5, 16'h005A, 0);
        // R7 shifts
        run_op(8, 1, 0, 16'h0080, 16'h0000, 0);
        run_op(8, 1, 1, 16'h4000, 16'h0000, 0);
        run_op(9, 1, 1, 16'h0001, 16'hFFFF, 0);
        run_op(9, 1, 0, 16'h0081, 16'h0000, 0);
        // R9 control commands
        run_op(10, 1, 1, 16'h0, 16'h0, 0);
        run_op(12, 1, 1, 16'h0, 16'h0, 0);
        run_op(14, 1, 0, 16'h0, 16'h0, 0);
        run_op(3, 1, 1, 16'h0001, 16'h0002, 0);
        check(flags[10:8] == 3'b111, "R9 controls survive data op", {13'h0, flags[10:8]}, 16'h0007);
        run_op(11, 1, 1, 16'h0, 16'h0, 0);
        run_op(13, 1, 1, 16'h0, 16'h0, 0);
        run_op(15, 1, 1, 16'h0, 16'h0, 0);
        // R10 idle
        run_op(1, 0, 1, 16'h1111, 16'h2222, 1);
        run_op(0, 1, 1, 16'h1111, 16'h2222, 1);

        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom % 16);
            bit v = ($urandom % 8) != 0;
            bit w = $urandom % 2;
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = 16'($urandom);
            if ($urandom % 6 == 0) b = a;
            run_op(op, v, w, a, b, bit'($urandom % 2));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule